// File: doc/BRIEF.md
# Programmable-Wait Asynchronous Memory Bus Controller

This block sits between an internal request port and an external asynchronous memory bus. It takes single read or write requests over a valid/ready handshake. For each request it drives one chip select, an address-valid strobe, and a read or write strobe. Every phase is a whole number of state-clock cycles, and one state-clock cycle (`clk_i`) is the timing unit. Phase lengths come from per-chip-select timing fields. Reads and writes have separate strobe and hold values but share one setup value. A per-chip-select option multiplexes the low address bits onto the data bus during the address phase.

An access runs through these phases in order: an optional one-unit gap from chip select to address-valid, one unit of address-valid, T0 units of setup, the strobe, and the hold. Chip select then returns high. The controller then refuses new requests for a programmed recovery interval. Read data is captured on the clock edge that raises the read strobe. A one-cycle `done_o` pulse returns the captured data.

Top module: `async_mem_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, every chip select and strobe is high, `bus_data_oe_o` is low, `req_ready_o` is high and `done_o` is low.
- R2: An access pulls low only the chip select numbered `req_cs_i`. Address-valid falls one cycle after chip select. When `short_gap_i[cs]` is 1, address-valid falls in the same cycle as chip select.
- R3: Address-valid stays low for exactly one cycle.
- R4: Between the rise of address-valid and the fall of the read or write strobe there are exactly T0 cycles. When `admux_i[cs]` is 1, the data bus drives the low address bits during the address-valid cycle and the setup cycles.
- R5: A read strobe is low for T1 cycles and a write strobe for T1W cycles. A field value of 0 gives one cycle. The read and write strobes are never low together.
- R6: Chip select rises T2 cycles (reads) or T2W cycles (writes) after the strobe rises. During a write, the write data is driven on the data bus for the whole strobe phase and the whole hold phase.
- R7: `rdata_o` holds the value of `bus_data_i` from the clock edge on which the read strobe rises. A read never enables the data-bus drivers.
- R8: `done_o` is high for exactly one cycle per access, in the first cycle in which chip select is back high.
- R9: Between two accesses, all chip selects stay high for at least CSInt+1 cycles. `req_ready_o` is low from acceptance until the recovery interval ends.
- R10: For chip select c, `rd_timing_i[16c+15:16c]` holds {CSInt, T2, T1, T0} as 4-bit fields, most significant first. `wr_timing_i[8c+7:8c]` holds {T2W, T1W}. A write takes its strobe and hold lengths from the write fields, and a read takes them from the read fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | State clock; one cycle is one timing unit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | CS_W | Chip-select index |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| rd_timing_i | input | 16*NUM_CS | Read/common timing fields per chip select |
| wr_timing_i | input | 8*NUM_CS | Write timing fields per chip select |
| short_gap_i | input | NUM_CS | Remove the chip-select-to-address-valid gap |
| admux_i | input | NUM_CS | Multiplexed address/data mode |
| bus_cs_no | output | NUM_CS | Active-low chip selects |
| bus_adv_no | output | 1 | Active-low address valid |
| bus_rd_no | output | 1 | Active-low read strobe |
| bus_wr_no | output | 1 | Active-low write strobe |
| bus_addr_o | output | ADDR_W | External address |
| bus_data_o | output | DATA_W | Data bus output value |
| bus_data_oe_o | output | 1 | Data bus drive enable (low = tri-stated) |
| bus_data_i | input | DATA_W | Data bus input value |

## Verification
The modelled memory changes its read data on every strobe cycle and floats a junk value outside the strobe. A controller that samples too early or during hold therefore returns the wrong word. Zero values for T0, T1, T2 and CSInt are mixed with the maximum value of 15. An off-by-one in skipping a phase, or a zero-width strobe, shows up as a wrong phase count. A write issued on a chip select whose read strobe setting differs from its write setting exposes a controller that uses the wrong timing set. Back-to-back requests measure the chip-select high time and catch a shortened recovery interval.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_GAP, PH_ADV, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV
  } phase_e;

  typedef struct packed {
    logic [3:0] t0;
    logic [3:0] strobe;
    logic [3:0] hold;
    logic [3:0] csint;
    logic       short_gap;
    logic       admux;
  } timing_t;
endpackage

// File: rtl/amc_timing_sel.sv
module amc_timing_sel
  import amc_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CS_W   = 1
) (
  input  logic [CS_W-1:0]     cs_idx_i,
  input  logic                we_i,
  input  logic [16*NUM_CS-1:0] rd_timing_i,
  input  logic [8*NUM_CS-1:0]  wr_timing_i,
  input  logic [NUM_CS-1:0]    short_gap_i,
  input  logic [NUM_CS-1:0]    admux_i,
  output timing_t              tim_o
);
  logic [15:0] rd_f;
  logic [7:0]  wr_f;
  logic [3:0]  strb_raw;

  always_comb begin
    rd_f = '0;
    wr_f = '0;
    tim_o = '0;
    if (int'(cs_idx_i) < NUM_CS) begin
      rd_f = rd_timing_i[16*int'(cs_idx_i) +: 16];
      wr_f = wr_timing_i[8*int'(cs_idx_i) +: 8];
      tim_o.short_gap = short_gap_i[cs_idx_i];
      tim_o.admux     = admux_i[cs_idx_i];
    end
    strb_raw     = we_i ? wr_f[3:0] : rd_f[7:4];
    tim_o.t0     = rd_f[3:0];
    tim_o.strobe = (strb_raw == 4'd0) ? 4'd1 : strb_raw;
    tim_o.hold   = we_i ? wr_f[7:4] : rd_f[11:8];
    tim_o.csint  = rd_f[15:12];
  end
endmodule

// File: rtl/amc_phase_cnt.sv
module amc_phase_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // counter only ever moves down by one or reloads
  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) && $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int MUX_W = (ADDR_W < DATA_W) ? ADDR_W : DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_we_i,
  input  logic [CS_W-1:0]        req_cs_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   done_o,
  output logic [DATA_W-1:0]      rdata_o,
  input  logic [16*NUM_CS-1:0]   rd_timing_i,
  input  logic [8*NUM_CS-1:0]    wr_timing_i,
  input  logic [NUM_CS-1:0]      short_gap_i,
  input  logic [NUM_CS-1:0]      admux_i,
  output logic [NUM_CS-1:0]      bus_cs_no,
  output logic                   bus_adv_no,
  output logic                   bus_rd_no,
  output logic                   bus_wr_no,
  output logic [ADDR_W-1:0]      bus_addr_o,
  output logic [DATA_W-1:0]      bus_data_o,
  output logic                   bus_data_oe_o,
  input  logic [DATA_W-1:0]      bus_data_i
);
  phase_e            state_q, state_d;
  timing_t           tim_sel, tim_q, tim_nxt;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [DATA_W-1:0] wdata_q, wdata_nxt, addr_lo;
  logic [CS_W-1:0]   cs_q, cs_nxt;
  logic              we_q, we_nxt;
  logic              accept, cnt_zero, load_d, done_d;
  logic [3:0]        load_val_d;
  logic              cs_low_d, addr_ph_d, data_ph_d;

  amc_timing_sel #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_tsel (
    .cs_idx_i   (req_cs_i),
    .we_i       (req_we_i),
    .rd_timing_i(rd_timing_i),
    .wr_timing_i(wr_timing_i),
    .short_gap_i(short_gap_i),
    .admux_i    (admux_i),
    .tim_o      (tim_sel)
  );

  amc_phase_cnt #(.W(4)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_d),
    .load_val_i(load_val_d),
    .zero_o    (cnt_zero)
  );

  assign req_ready_o = (state_q == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  assign tim_nxt   = accept ? tim_sel     : tim_q;
  assign addr_nxt  = accept ? req_addr_i  : addr_q;
  assign wdata_nxt = accept ? req_wdata_i : wdata_q;
  assign cs_nxt    = accept ? req_cs_i    : cs_q;
  assign we_nxt    = accept ? req_we_i    : we_q;

  always_comb begin
    addr_lo = '0;
    for (int i = 0; i < MUX_W; i++) addr_lo[i] = addr_nxt[i];
  end

  // phase sequencing; zero-length phases are skipped
  always_comb begin
    state_d    = state_q;
    load_d     = 1'b0;
    load_val_d = '0;
    done_d     = 1'b0;
    unique case (state_q)
      PH_IDLE: if (accept) begin
        state_d = tim_sel.short_gap ? PH_ADV : PH_GAP;
        load_d  = 1'b1;
      end
      PH_GAP: begin
        state_d = PH_ADV;
        load_d  = 1'b1;
      end
      PH_ADV: begin
        load_d = 1'b1;
        if (tim_q.t0 != '0) begin
          state_d = PH_SETUP;  load_val_d = tim_q.t0 - 1'b1;
        end else begin
          state_d = PH_STROBE; load_val_d = tim_q.strobe - 1'b1;
        end
      end
      PH_SETUP: if (cnt_zero) begin
        state_d = PH_STROBE; load_d = 1'b1; load_val_d = tim_q.strobe - 1'b1;
      end
      PH_STROBE, PH_HOLD: if (cnt_zero) begin
        load_d = 1'b1;
        if (state_q == PH_STROBE && tim_q.hold != '0) begin
          state_d = PH_HOLD; load_val_d = tim_q.hold - 1'b1;
        end else begin
          done_d = 1'b1;
          if (tim_q.csint != '0) begin
            state_d = PH_RECOV; load_val_d = tim_q.csint - 1'b1;
          end else begin
            state_d = PH_IDLE;
          end
        end
      end
      PH_RECOV: if (cnt_zero) state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  assign cs_low_d  = state_d inside {PH_GAP, PH_ADV, PH_SETUP, PH_STROBE, PH_HOLD};
  assign addr_ph_d = state_d inside {PH_ADV, PH_SETUP};
  assign data_ph_d = tim_nxt.admux ? (state_d inside {PH_STROBE, PH_HOLD})
                                   : (state_d inside {PH_ADV, PH_SETUP, PH_STROBE, PH_HOLD});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      tim_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      cs_q    <= '0;
      we_q    <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      state_q <= state_d;
      tim_q   <= tim_nxt;
      addr_q  <= addr_nxt;
      wdata_q <= wdata_nxt;
      cs_q    <= cs_nxt;
      we_q    <= we_nxt;
      done_o  <= done_d;
      // sample on the edge that raises the read strobe
      if (state_q == PH_STROBE && cnt_zero && !we_q) rdata_o <= bus_data_i;
    end
  end

  // strobes registered straight from next state
  generate
    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bus_cs_no[c] <= 1'b1;
        else         bus_cs_no[c] <= !(cs_low_d && int'(cs_nxt) == c);
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_adv_no    <= 1'b1;
      bus_rd_no     <= 1'b1;
      bus_wr_no     <= 1'b1;
      bus_addr_o    <= '0;
      bus_data_o    <= '0;
      bus_data_oe_o <= 1'b0;
    end else begin
      bus_adv_no    <= !(state_d == PH_ADV);
      bus_rd_no     <= !(state_d == PH_STROBE && !we_nxt);
      bus_wr_no     <= !(state_d == PH_STROBE && we_nxt);
      if (cs_low_d) bus_addr_o <= addr_nxt;
      bus_data_o    <= (tim_nxt.admux && addr_ph_d) ? addr_lo : wdata_nxt;
      bus_data_oe_o <= (tim_nxt.admux && addr_ph_d) || (we_nxt && data_ph_d);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&bus_cs_no) |-> (bus_adv_no && bus_rd_no && bus_wr_no && !bus_data_oe_o));
  assert_one_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~bus_cs_no) <= 1);
  assert_adv_in_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_adv_no |-> !(&bus_cs_no));
  assert_adv_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_adv_no |=> bus_adv_no);
  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_no || bus_wr_no);
  assert_rd_no_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_no |-> !bus_data_oe_o);
  assert_done_at_cs_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((&bus_cs_no) && !(&$past(bus_cs_no))));
  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&bus_cs_no) |-> !req_ready_o);
endmodule

// File: tb/async_mem_ctrl_test.sv
module async_mem_ctrl_test;
  localparam int NUM_CS = 2;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CS_W   = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                 req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [CS_W-1:0]      req_cs = '0;
  logic [ADDR_W-1:0]    req_addr = '0;
  logic [DATA_W-1:0]    req_wdata = '0;
  logic                 done;
  logic [DATA_W-1:0]    rdata;
  logic [16*NUM_CS-1:0] rd_tim = '0;
  logic [8*NUM_CS-1:0]  wr_tim = '0;
  logic [NUM_CS-1:0]    short_gap = '0, admux = '0;
  logic [NUM_CS-1:0]    cs_n;
  logic                 adv_n, rd_n, wr_n, oe;
  logic [ADDR_W-1:0]    baddr;
  logic [DATA_W-1:0]    bdata_o;
  logic [DATA_W-1:0]    mem_drv = 16'hDEAD;

  async_mem_ctrl #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_cs_i(req_cs), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata),
    .rd_timing_i(rd_tim), .wr_timing_i(wr_tim),
    .short_gap_i(short_gap), .admux_i(admux),
    .bus_cs_no(cs_n), .bus_adv_no(adv_n), .bus_rd_no(rd_n), .bus_wr_no(wr_n),
    .bus_addr_o(baddr), .bus_data_o(bdata_o), .bus_data_oe_o(oe),
    .bus_data_i(mem_drv)
  );

  typedef struct {
    int cs; bit we; bit mux;
    logic [15:0] addr, wdata, rexp;
    int gap, t0, strb, hold, csint;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] mem_pat(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: program fields (R10 layout), push expectation, handshake
  task automatic access(input int cs, input bit we, input logic [15:0] addr,
                        input logic [15:0] wd, input int t0, input int t1,
                        input int t2, input int csint, input int t1w,
                        input int t2w, input bit sg, input bit mux);
    exp_t e;
    @(negedge clk);
    rd_tim[16*cs +: 16] = {4'(csint), 4'(t2), 4'(t1), 4'(t0)};
    wr_tim[8*cs +: 8]   = {4'(t2w), 4'(t1w)};
    short_gap[cs] = sg;
    admux[cs]     = mux;
    e.cs = cs; e.we = we; e.mux = mux; e.addr = addr; e.wdata = wd;
    e.gap  = sg ? 0 : 1;
    e.t0   = t0;
    e.strb = we ? ((t1w == 0) ? 1 : t1w) : ((t1 == 0) ? 1 : t1);
    e.hold = we ? t2w : t2;
    e.csint = csint;
    e.rexp = mem_pat(addr) ^ 16'(e.strb);
    q.push_back(e);
    req_cs = CS_W'(cs); req_we = we; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  bit in_acc = 0, have_prev = 0;
  int phase = 0, c_gap = 0, c_adv = 0, c_setup = 0, c_strb = 0, c_hold = 0;
  int hi_cnt = 0, prev_csint = 0;
  exp_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      mem_drv = 16'hDEAD;
      if (!(&cs_n)) begin
        if (!in_acc) begin
          in_acc = 1; phase = 0;
          c_gap = 0; c_adv = 0; c_setup = 0; c_strb = 0; c_hold = 0;
          if (have_prev)
            chk(hi_cnt >= prev_csint + 1, "R9", "cs high gap", hi_cnt, prev_csint + 1);
          chk(q.size() != 0, "R2", "unexpected access", q.size(), 1);
          if (q.size() != 0) begin
            cur = q[0];
            chk(cs_n == ~(NUM_CS'(1) << cur.cs), "R2", "chip select line",
                cs_n, ~(NUM_CS'(1) << cur.cs));
            chk(baddr == cur.addr, "R2", "address", baddr, cur.addr);
          end
        end
        chk(!done, "R8", "done during access", done, 0);
        chk(!req_ready, "R9", "ready during access", req_ready, 0);
        if (!adv_n) begin
          c_adv++; phase = 1;
          if (cur.mux) chk(oe && bdata_o == cur.addr, "R4", "muxed addr in adv", bdata_o, cur.addr);
        end else if (!rd_n || !wr_n) begin
          phase = 3; c_strb++;
          chk(wr_n == !cur.we && rd_n == cur.we, "R5", "strobe kind", {rd_n, wr_n}, {cur.we, !cur.we});
          if (cur.we) chk(oe && bdata_o == cur.wdata, "R6", "wdata in strobe", bdata_o, cur.wdata);
          else begin
            chk(!oe, "R7", "read drives bus", oe, 0);
            mem_drv = mem_pat(cur.addr) ^ 16'(c_strb);
          end
        end else if (phase == 0) begin
          c_gap++;
        end else if (phase <= 2) begin
          phase = 2; c_setup++;
          if (cur.mux) chk(oe && bdata_o == cur.addr, "R4", "muxed addr in setup", bdata_o, cur.addr);
        end else begin
          phase = 4; c_hold++;
          if (cur.we) chk(oe && bdata_o == cur.wdata, "R6", "wdata in hold", bdata_o, cur.wdata);
        end
      end else if (in_acc) begin
        in_acc = 0;
        chk(done, "R8", "done at cs rise", done, 1);
        chk(oe == 0, "R1", "oe after access", oe, 0);
        if (q.size() != 0) begin
          cur = q.pop_front();
          chk(c_gap == cur.gap, "R2", "cs-to-adv gap", c_gap, cur.gap);
          chk(c_adv == 1, "R3", "adv width", c_adv, 1);
          chk(c_setup == cur.t0, "R4", "setup cycles", c_setup, cur.t0);
          chk(c_strb == cur.strb, "R5", "strobe width (R10 field select)", c_strb, cur.strb);
          chk(c_hold == cur.hold, "R6", "hold cycles (R10 field select)", c_hold, cur.hold);
          if (!cur.we) chk(rdata == cur.rexp, "R7", "read data", rdata, cur.rexp);
          prev_csint = cur.csint;
        end
        have_prev = 1; hi_cnt = 1;
      end else begin
        hi_cnt++;
        chk(!done, "R8", "spurious done", done, 0);
        chk(!oe && adv_n && rd_n && wr_n, "R1", "idle bus", {oe, adv_n, rd_n, wr_n}, 4'b0111);
      end
    end
  end

  // watchdog
  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd_cnt, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == '1 && adv_n && rd_n && wr_n, "R1", "strobes in reset", {cs_n, adv_n, rd_n, wr_n}, 5'h1F);
    chk(!oe && !done, "R1", "oe/done in reset", {oe, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && cs_n == '1, "R1", "ready after reset", {req_ready, cs_n}, 3'b111);

    access(0, 0, 16'h1234, 16'h0,    2, 3, 1, 2, 0, 0, 0, 0);
    access(1, 1, 16'h2222, 16'hBEEF, 1, 0, 0, 0, 2, 3, 1, 0);
    access(1, 0, 16'h3333, 16'h0,    0, 0, 0, 0, 0, 0, 0, 1);
    access(0, 1, 16'h4444, 16'hCAFE, 3, 5, 5, 5, 0, 0, 1, 1);
    access(0, 0, 16'h5555, 16'h0,    15, 15, 15, 15, 0, 0, 0, 0);
    // R10: write must use T1W/T2W, not the read fields
    access(1, 1, 16'h6666, 16'h1357, 2, 7, 6, 3, 2, 1, 0, 0);
    access(1, 0, 16'h7777, 16'h0,    1, 7, 6, 3, 2, 1, 0, 1);
    access(0, 1, 16'h8888, 16'h2468, 0, 0, 0, 1, 15, 15, 1, 1);
    access(0, 0, 16'h9999, 16'h0,    4, 1, 2, 0, 0, 0, 1, 0);
    access(1, 1, 16'hAAAA, 16'hFFFF, 0, 0, 0, 0, 0, 0, 1, 0);

    for (int i = 0; i < 2000 && (q.size() != 0 || in_acc); i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R8", "all accesses completed", q.size(), 0);
    finish_run();
  end
endmodule